// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This block is the multi-cycle integer divider of a 64-bit core. It produces the quotient or the remainder of two operands, signed or unsigned, either on the full 64-bit width or in word mode. In word mode only the low 32 bits of each operand are used, and the 32-bit answer is sign-extended to 64 bits. It never raises an exception. A zero divisor and the one signed overflow case give fixed results instead.

A request is a valid/ready transfer that carries both operands, a 2-bit operation code and a word flag. The unit accepts a request only while it is idle. It works on operand magnitudes with a restoring algorithm that makes one quotient bit per cycle. It then corrects the signs and presents the result on a response that stays valid until the consumer takes it. The zero-divisor and overflow cases are found when the request is accepted and are answered without iterating.

Top module: `int_divider`

## Requirements
- R1: Operation code bit 0 set means unsigned and bit 1 set means remainder: 0 = signed quotient, 1 = unsigned quotient, 2 = signed remainder, 3 = unsigned remainder. In full mode, quotients truncate toward zero.
- R2: A remainder satisfies dividend = quotient × divisor + remainder. In signed operations the remainder takes the sign of the dividend.
- R3: A zero divisor gives a quotient with every bit set, for both signed and unsigned operations.
- R4: A zero divisor gives a remainder equal to the dividend as it was extended for the mode in use.
- R5: A signed operation with the most negative dividend and a divisor of minus one gives the dividend as the quotient and zero as the remainder.
- R6: In signed word mode, both operands are the sign extension of their low 32 bits. The 32-bit result is sign-extended to 64 bits.
- R7: In unsigned word mode, both operands are the zero extension of their low 32 bits. The 32-bit result is still sign-extended to 64 bits.
- R8: A zero-divisor or overflow request has its response valid one clock edge after it is accepted. Any other request takes 65 edges in full mode and 33 in word mode.
- R9: req_ready is high only while idle. A request presented while the unit is busy or holding a response is neither taken nor queued.
- R10: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_result does not change.
- R11: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_a | input | 64 | Dividend |
| req_b | input | 64 | Divisor |
| req_op | input | 2 | Operation code (see R1) |
| req_word | input | 1 | Word mode |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_result | output | 64 | Quotient or remainder |

## Verification
The bench targets the zero divisor in all four operations and both modes. A design that trapped or divided there would return garbage instead of all-ones or the dividend. It also drives the most negative value divided by minus one, in full and word forms. That case exposes a sign fix-up that negates the overflowed magnitude, or a word overflow test that checks the wrong width. Unsigned word operands with bit 31 set catch a result that is zero-extended or an operand that is sign-extended. Negative dividends and divisors in every sign combination expose remainder sign errors. Further tests cover busy-time requests, a stalled response and the latency counts. These catch dropped handshakes, queued requests and miscounted iterations.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        OP_DIV  = 2'd0,
        OP_DIVU = 2'd1,
        OP_REM  = 2'd2,
        OP_REMU = 2'd3
    } div_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUSY = 2'd1,
        S_RESP = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: mode extension, magnitudes, sign plan, special cases.
module div_prep #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    input  logic         word,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_q,
    output logic         neg_r,
    output logic         special,
    output logic [W-1:0] sp_quo,
    output logic [W-1:0] sp_rem
);
    localparam int HW = W / 2;

    logic         is_signed;
    logic [W-1:0] ext_a, ext_b, min_val;
    logic         zero_div, ovf;

    always_comb begin
        is_signed = ~op[0];
        if (word) begin
            ext_a = is_signed ? {{HW{a[HW-1]}}, a[HW-1:0]} : {{HW{1'b0}}, a[HW-1:0]};
            ext_b = is_signed ? {{HW{b[HW-1]}}, b[HW-1:0]} : {{HW{1'b0}}, b[HW-1:0]};
            min_val = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};
        end else begin
            ext_a = a;
            ext_b = b;
            min_val = {1'b1, {(W-1){1'b0}}};
        end
        zero_div = (ext_b == '0);
        ovf      = is_signed && (ext_a == min_val) && (ext_b == '1);
        special  = zero_div || ovf;
        neg_q    = is_signed && (ext_a[W-1] ^ ext_b[W-1]);
        neg_r    = is_signed && ext_a[W-1];
        mag_a    = (is_signed && ext_a[W-1]) ? (~ext_a + 1'b1) : ext_a;
        mag_b    = (is_signed && ext_b[W-1]) ? (~ext_b + 1'b1) : ext_b;
        if (zero_div) begin
            sp_quo = '1;
            sp_rem = ext_a;
        end else begin
            sp_quo = ext_a;
            sp_rem = '0;
        end
    end
endmodule

// File: rtl/div_step.sv
// One restoring iteration: one quotient bit.
module div_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W:0] shifted, diff;
    logic       take;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvs};
        take    = ~diff[W];
        rem_n   = take ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo[W-2:0], take};
    end
endmodule

// File: rtl/div_fix.sv
// Sign correction, result select and word-mode extension.
module div_fix #(
    parameter int W = 64
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         want_rem,
    input  logic         word,
    output logic [W-1:0] result
);
    localparam int HW = W / 2;

    logic [W-1:0] q_s, r_s, sel;

    always_comb begin
        q_s = neg_q ? (~quo + 1'b1) : quo;
        r_s = neg_r ? (~rem + 1'b1) : rem;
        sel = want_rem ? r_s : q_s;
        result = word ? {{HW{sel[HW-1]}}, sel[HW-1:0]} : sel;
    end
endmodule

// File: rtl/int_divider.sv
module int_divider
    import div_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [W-1:0] req_a,
    input  logic [W-1:0] req_b,
    input  logic [1:0]   req_op,
    input  logic         req_word,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic [W-1:0] rsp_result
);
    localparam int HW = W / 2;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        div_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] dvs;
        logic         neg_q;
        logic         neg_r;
        logic         want_rem;
        logic         word;
        logic [W-1:0] result;
    } regs_t;

    regs_t q, d;

    logic [W-1:0] p_mag_a, p_mag_b, p_sp_quo, p_sp_rem;
    logic         p_neg_q, p_neg_r, p_special;
    logic [W-1:0] s_rem, s_quo;
    logic [W-1:0] f_quo, f_rem, f_result;
    logic         f_neg_q, f_neg_r, f_want_rem, f_word;
    logic         accept;

    div_prep #(.W(W)) i_prep (
        .a(req_a), .b(req_b), .op(req_op), .word(req_word),
        .mag_a(p_mag_a), .mag_b(p_mag_b), .neg_q(p_neg_q), .neg_r(p_neg_r),
        .special(p_special), .sp_quo(p_sp_quo), .sp_rem(p_sp_rem)
    );

    div_step #(.W(W)) i_step (
        .rem(q.rem), .quo(q.quo), .dvs(q.dvs), .rem_n(s_rem), .quo_n(s_quo)
    );

    div_fix #(.W(W)) i_fix (
        .quo(f_quo), .rem(f_rem), .neg_q(f_neg_q), .neg_r(f_neg_r),
        .want_rem(f_want_rem), .word(f_word), .result(f_result)
    );

    assign req_ready  = (q.st == S_IDLE);
    assign rsp_valid  = (q.st == S_RESP);
    assign rsp_result = q.result;
    assign accept     = req_valid && req_ready;

    // Fix-up inputs: special answers at issue, iteration results otherwise.
    always_comb begin
        if (q.st == S_IDLE) begin
            f_quo      = p_sp_quo;
            f_rem      = p_sp_rem;
            f_neg_q    = 1'b0;
            f_neg_r    = 1'b0;
            f_want_rem = req_op[1];
            f_word     = req_word;
        end else begin
            f_quo      = s_quo;
            f_rem      = s_rem;
            f_neg_q    = q.neg_q;
            f_neg_r    = q.neg_r;
            f_want_rem = q.want_rem;
            f_word     = q.word;
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.want_rem = req_op[1];
                    d.word     = req_word;
                    d.neg_q    = p_neg_q;
                    d.neg_r    = p_neg_r;
                    if (p_special) begin
                        d.result = f_result;
                        d.st     = S_RESP;
                    end else begin
                        d.rem = '0;
                        d.quo = req_word ? (p_mag_a << HW) : p_mag_a;
                        d.dvs = p_mag_b;
                        d.cnt = req_word ? CW'(HW) : CW'(W);
                        d.st  = S_BUSY;
                    end
                end
            end
            S_BUSY: begin
                d.rem = s_rem;
                d.quo = s_quo;
                d.cnt = q.cnt - 1'b1;
                if (q.cnt == CW'(1)) begin
                    d.result = f_result;
                    d.st     = S_RESP;
                end
            end
            S_RESP: begin
                if (rsp_ready) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // Partial remainder stays below the divisor (R1, R2).
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BUSY && q.dvs != '0) |-> (q.rem < q.dvs));

    a_r8_special_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && p_special) |=> rsp_valid);

    a_r8_normal_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !p_special) |=> !rsp_valid);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    a_r10_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result)));

    // Word results are sign-extended from bit HW-1 (R6, R7).
    a_r7_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.word) |-> (rsp_result[W-1:HW] == {HW{rsp_result[HW-1]}}));

    a_r11_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));
endmodule

// File: tb/test_int_divider.sv
module test_int_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic [1:0]  req_op = '0;
    logic        req_word = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_result;

    int total = 0;
    int bad = 0;
    int lat;

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    int_divider #(.W(64)) i_int_divider (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_a(req_a), .req_b(req_b), .req_op(req_op), .req_word(req_word),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_result(rsp_result)
    );

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] op, input bit w);
        logic sgn;
        logic [63:0] ea, eb, qv, rv, res;
        sgn = ~op[0];
        if (w) begin
            ea = sgn ? {{32{a[31]}}, a[31:0]} : {32'b0, a[31:0]};
            eb = sgn ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]};
        end else begin
            ea = a;
            eb = b;
        end
        if (eb == 64'd0) begin
            qv = ONES;
            rv = ea;
        end else if (sgn && ea == MIN64 && eb == ONES) begin
            qv = ea;
            rv = 64'd0;
        end else if (sgn) begin
            qv = $signed(ea) / $signed(eb);
            rv = $signed(ea) % $signed(eb);
        end else begin
            qv = ea / eb;
            rv = ea % eb;
        end
        res = op[1] ? rv : qv;
        if (w) res = {{32{res[31]}}, res[31:0]};
        return res;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] op, input bit w);
        int guard;
        guard = 0;
        @(negedge clk);
        req_a = a; req_b = b; req_op = op; req_word = w; req_valid = 1'b1;
        while (!req_ready && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
    endtask

    // Waits for the response (lat counts edges since accept), checks, consumes.
    task automatic collect(input logic [63:0] exp, input string tag, input int exp_lat);
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid && rsp_result == exp, tag, rsp_result, exp);
        if (exp_lat > 0)
            chk(lat == exp_lat, {tag, " R8 latency"}, 64'(lat), 64'(exp_lat));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] op, input bit w, input string tag);
        issue(a, b, op, w);
        collect(model(a, b, op, w), tag, 0);
    endtask

    task automatic t_reset();
        chk(!rsp_valid && req_ready, "R11 reset state", {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    task automatic t_full_signs();
        // R1 quotients and R2 remainders in every sign combination
        for (int s = 0; s < 4; s++) begin
            logic [63:0] a, b;
            a = s[0] ? -64'd1000003 : 64'd1000003;
            b = s[1] ? -64'd97 : 64'd97;
            run(a, b, 2'd0, 1'b0, "R1 signed quotient");
            run(a, b, 2'd2, 1'b0, "R2 signed remainder");
            run(a, b, 2'd1, 1'b0, "R1 unsigned quotient");
            run(a, b, 2'd3, 1'b0, "R2 unsigned remainder");
        end
        run(ONES, 64'd1, 2'd1, 1'b0, "R1 unsigned max by one");
        run(64'd5, 64'd7, 2'd0, 1'b0, "R1 small over large");
    endtask

    task automatic t_zero();
        for (int op = 0; op < 4; op++) begin
            for (int w = 0; w < 2; w++) begin
                logic [63:0] a;
                a = 64'h1234_5678_9ABC_DEF0;
                issue(a, 64'd0, 2'(op), w[0]);
                collect(model(a, 64'd0, 2'(op), w[0]),
                        op[1] ? "R4 remainder by zero" : "R3 quotient by zero", 1);
            end
        end
        // upper bits nonzero but low word zero: word mode treats divisor as zero
        run(64'hFFFF_0000_8000_0001, 64'h0000_0001_0000_0000, 2'd1, 1'b1, "R3 word zero divisor");
        run(64'hFFFF_0000_8000_0001, 64'h0000_0001_0000_0000, 2'd3, 1'b1, "R4 word zero divisor");
    endtask

    task automatic t_ovf();
        issue(MIN64, ONES, 2'd0, 1'b0);
        collect(MIN64, "R5 full overflow quotient", 1);
        issue(MIN64, ONES, 2'd2, 1'b0);
        collect(64'd0, "R5 full overflow remainder", 1);
        issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'd0, 1'b1);
        collect(64'hFFFF_FFFF_8000_0000, "R5 word overflow quotient", 1);
        issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'd2, 1'b1);
        collect(64'd0, "R5 word overflow remainder", 1);
        run(MIN64, ONES, 2'd1, 1'b0, "R5 unsigned not overflow");
    endtask

    task automatic t_word();
        run(64'hAAAA_AAAA_FFFF_FFF9, 64'h5555_5555_0000_0002, 2'd0, 1'b1, "R6 signed word quotient");
        run(64'hAAAA_AAAA_FFFF_FFF9, 64'h5555_5555_0000_0002, 2'd2, 1'b1, "R6 signed word remainder");
        run(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFD, 2'd0, 1'b1, "R6 signed word neg divisor");
        run(64'h1111_1111_F000_0000, 64'h0000_0000_0000_0001, 2'd1, 1'b1, "R7 unsigned word sext result");
        run(64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0010, 2'd1, 1'b1, "R7 unsigned word quotient");
        run(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_8000_0000, 2'd3, 1'b1, "R7 unsigned word remainder");
    endtask

    task automatic t_latency();
        issue(64'd1000, 64'd7, 2'd0, 1'b0);
        collect(64'd142, "R8 full latency", 65);
        issue(64'd1000, 64'd7, 2'd3, 1'b1);
        collect(64'd6, "R8 word latency", 33);
    endtask

    task automatic t_busy();
        issue(64'd500, 64'd10, 2'd0, 1'b0);
        req_a = 64'd9; req_b = 64'd0; req_op = 2'd2; req_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            chk(!req_ready, "R9 ready low while busy", {63'd0, req_ready}, 64'd0);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        collect(64'd50, "R9 busy request ignored", 65);
        for (int i = 0; i < 3; i++) begin
            chk(!rsp_valid, "R9 nothing queued", {63'd0, rsp_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_hold();
        logic [63:0] first;
        issue(-64'd77, 64'd5, 2'd2, 1'b0);
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        first = rsp_result;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_result == first, "R10 response held", rsp_result, first);
        end
        collect(-64'd2, "R10 held value", 0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 48; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 3 == 1) b = b >> (i % 60);
            if (i % 5 == 2) b = -64'(i % 7 + 1);
            run(a, b, 2'(i % 4), i[2], "R1 R2 R6 R7 random");
        end
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=done", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_signs();
        t_zero();
        t_ovf();
        t_word();
        t_latency();
        t_busy();
        t_hold();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule